// File: doc/BRIEF.md
# Decimal Address Digit Decoder and Checker

This block holds a multi-digit decimal memory address and turns every digit into ten select lines for a core matrix. Each digit has four BCD bits plus one check bit. The digit decoders are deliberately incomplete. Lines 3 to 7 ignore the 8 bit, and lines 8 and 9 look mainly at the 8 bit and the 1 bit. An illegal code therefore raises either no line or two lines. It is passed to the matrix as it is.

Near the end of every memory cycle an end-of-cycle strobe samples a check of the held address. The check finds any digit whose parity is even. It also finds a high-order digit larger than the installed memory allows. Any error sets a sticky check flag and raises a halt output, and both stay set until a synchronous clear. Each digit also has two diagnostic outputs, no line active and more than one line active. These outputs never feed the halt.

Top module: `dec_addr_select`

## Requirements
- R1: For a held digit code n from 0 to 9, exactly select line n of that digit is high. Digit k drives sel_o[10k+9:10k], digit 0 is the lowest order, and digit NUM_DIGITS-1 is the high-order digit.
- R2: Code 1010 raises no select line. Codes 1011, 1100, 1101, 1110 and 1111 each raise exactly two lines, in this order: 3 and 9, 4 and 8, 5 and 9, 6 and 8, 7 and 9.
- R3: For each digit, none_o[k] is high when none of its lines is active, and multi_o[k] is high when two or more are active. These outputs never set check_o or halt_o.
- R4: A clock edge with load_i high captures addr_i into the address register. Digit k is addr_i[5k+4:5k], where bit 4 is the check bit and bits 3:0 are the BCD code. Without load_i the register holds.
- R5: A clock edge with strobe_i high sets check_o when any held digit has an even number of ones across its five bits.
- R6: A strobe also sets check_o when the high-order BCD code is greater than MAX_HIGH_DIGIT (default 1). This includes codes above 1001. Lower digits with codes above 1001 and odd parity are not flagged.
- R7: halt_o is high whenever check_o is high. It is also high during a strobe cycle in which an error is present, before the flag registers.
- R8: check_o stays set until a clock edge with clear_i high. If clear_i and a failing strobe arrive in the same cycle, clear_i wins.
- R9: Reset (rst_ni low) empties the address register to all-zero digits and clears check_o.
- R10: Errors in the held address have no effect on check_o or halt_o while strobe_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the address register |
| addr_i | input | NUM_DIGITS*5 | Address digits, each {check, bcd[3:0]} |
| strobe_i | input | 1 | End-of-cycle check strobe |
| clear_i | input | 1 | Synchronous clear of the check flag |
| sel_o | output | NUM_DIGITS*10 | Select lines, ten per digit |
| none_o | output | NUM_DIGITS | Diagnostic: digit raises no line |
| multi_o | output | NUM_DIGITS | Diagnostic: digit raises several lines |
| check_o | output | 1 | Sticky address check flag |
| halt_o | output | 1 | Halt request |

## Verification
Every cycle, the assertions check the following. A legal code gives a single select line. Code 1010 gives none, and the other illegal codes give exactly two. A load captures the input. The flag stays set until it is cleared, a clear wins over a strobe, and halt follows the flag. The bench scenarios show the rest. These are the exact pair of lines for each illegal code and the diagnostic outputs. They also cover the range limit on the high digit only, and that lower digits with illegal codes and good parity pass unflagged. The last ones are that errors do nothing without a strobe and that halt rises within the strobe cycle itself.

// File: rtl/dec_addr_pkg.sv
package dec_addr_pkg;
  localparam int unsigned BCD_W  = 4;
  localparam int unsigned DIG_W  = BCD_W + 1;
  localparam int unsigned N_LINE = 10;

  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [N_LINE-1:0] lines_t;
endpackage

// File: rtl/dec_digit_sel.sv
module dec_digit_sel
  import dec_addr_pkg::*;
(
  input  logic [BCD_W-1:0] bcd_i,
  output lines_t           sel_o,
  output logic             none_o,
  output logic             multi_o
);
  logic b8, b4, b2, b1;
  assign {b8, b4, b2, b1} = bcd_i;

  // 0..2 fully decoded; 3..7 leave the 8 bit open; 8/9 mostly 8 and 1 bits
  always_comb begin
    sel_o    = '0;
    sel_o[0] = !b8 && !b4 && !b2 && !b1;
    sel_o[1] = !b8 && !b4 && !b2 &&  b1;
    sel_o[2] = !b8 && !b4 &&  b2 && !b1;
    sel_o[3] = !b4 &&  b2 &&  b1;
    sel_o[4] =  b4 && !b2 && !b1;
    sel_o[5] =  b4 && !b2 &&  b1;
    sel_o[6] =  b4 &&  b2 && !b1;
    sel_o[7] =  b4 &&  b2 &&  b1;
    sel_o[8] =  b8 && !b1 && !(b2 && !b4);
    sel_o[9] =  b8 &&  b1;
  end

  assign none_o  = (sel_o == '0);
  assign multi_o = ($countones(sel_o) > 1);

  always_comb begin
    if (!$isunknown(bcd_i)) begin
      if (bcd_i <= 4'd9) begin
        a_r1_valid_onehot: assert (sel_o == lines_t'(1) << bcd_i);
      end else if (bcd_i == 4'd10) begin
        a_r2_code_a_empty: assert (sel_o == '0);
      end else begin
        a_r2_invalid_pair: assert ($countones(sel_o) == 2);
      end
    end
  end
endmodule

// File: rtl/dec_addr_err.sv
module dec_addr_err
  import dec_addr_pkg::*;
#(
  parameter int unsigned NUM_DIGITS     = 5,
  parameter int unsigned MAX_HIGH_DIGIT = 1
) (
  input  digit_t                 dig_i [NUM_DIGITS],
  output logic [NUM_DIGITS-1:0]  par_err_o,
  output logic                   range_err_o,
  output logic                   err_o
);
  localparam logic [BCD_W-1:0] MAX_HI = BCD_W'(MAX_HIGH_DIGIT);

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_par
    assign par_err_o[k] = ~^dig_i[k];  // odd parity required
  end

  assign range_err_o = dig_i[NUM_DIGITS-1][BCD_W-1:0] > MAX_HI;
  assign err_o       = |par_err_o || range_err_o;
endmodule

// File: rtl/dec_addr_select.sv
module dec_addr_select
  import dec_addr_pkg::*;
#(
  parameter int unsigned NUM_DIGITS     = 5,
  parameter int unsigned MAX_HIGH_DIGIT = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NUM_DIGITS*DIG_W-1:0]  addr_i,
  input  logic                         strobe_i,
  input  logic                         clear_i,
  output logic [NUM_DIGITS*N_LINE-1:0] sel_o,
  output logic [NUM_DIGITS-1:0]        none_o,
  output logic [NUM_DIGITS-1:0]        multi_o,
  output logic                         check_o,
  output logic                         halt_o
);
  localparam int unsigned ADDR_W = NUM_DIGITS * DIG_W;

  logic [ADDR_W-1:0]     addr_q;
  digit_t                dig    [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] par_err;
  logic                  range_err;
  logic                  err_now;
  logic                  check_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    assign dig[k] = addr_q[k*DIG_W +: DIG_W];
    dec_digit_sel u_sel (
      .bcd_i   (dig[k][BCD_W-1:0]),
      .sel_o   (sel_o[k*N_LINE +: N_LINE]),
      .none_o  (none_o[k]),
      .multi_o (multi_o[k])
    );
  end

  dec_addr_err #(
    .NUM_DIGITS     (NUM_DIGITS),
    .MAX_HIGH_DIGIT (MAX_HIGH_DIGIT)
  ) u_err (
    .dig_i       (dig),
    .par_err_o   (par_err),
    .range_err_o (range_err),
    .err_o       (err_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  check_q <= 1'b0;
    else if (clear_i)             check_q <= 1'b0;
    else if (strobe_i && err_now) check_q <= 1'b1;
  end

  assign check_o = check_q;
  assign halt_o  = check_q || (strobe_i && err_now);

  a_r4_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_q == $past(addr_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_q));
  a_r5_strobe_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && err_now && !clear_i |=> check_o);
  a_r7_halt_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o |-> halt_o);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o && !clear_i |=> check_o);
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !check_o);
  a_r10_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_o && !strobe_i |=> !check_o);
endmodule

// File: tb/tb_dec_addr_select.sv
module tb_dec_addr_select;
  localparam int ND = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [ND*5-1:0]  addr_i = '0;
  logic          strobe_i = 1'b0;
  logic          clear_i = 1'b0;
  logic [ND*10-1:0] sel_o;
  logic [ND-1:0] none_o, multi_o;
  logic          check_o, halt_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  dec_addr_select #(.NUM_DIGITS(ND), .MAX_HIGH_DIGIT(1)) dut (
    .clk_i, .rst_ni, .load_i, .addr_i, .strobe_i, .clear_i,
    .sel_o, .none_o, .multi_o, .check_o, .halt_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic [4:0] gd(input [3:0] c);  // good-parity digit
    return {~^c, c};
  endfunction

  function automatic [9:0] exp_sel(input [3:0] c);
    case (c)
      4'd10:   return 10'd0;
      4'd11:   return (10'd1 << 3) | (10'd1 << 9);
      4'd12:   return (10'd1 << 4) | (10'd1 << 8);
      4'd13:   return (10'd1 << 5) | (10'd1 << 9);
      4'd14:   return (10'd1 << 6) | (10'd1 << 8);
      4'd15:   return (10'd1 << 7) | (10'd1 << 9);
      default: return 10'd1 << c;
    endcase
  endfunction

  task automatic load(input logic [ND*5-1:0] a);
    @(negedge clk_i); addr_i = a; load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
  endtask

  // strobe one cycle; report halt seen before the edge
  task automatic strobe(output logic halt_pre);
    @(negedge clk_i); strobe_i = 1'b1;
    #1 halt_pre = halt_o;
    @(negedge clk_i); strobe_i = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 sel after reset", 64'(sel_o), 64'({ND{10'd1}}));
    chk("R9 check after reset", 64'(check_o), 64'd0);
    chk("R9 halt after reset", 64'(halt_o), 64'd0);
  endtask

  task automatic t_valid();
    for (int n = 0; n < 10; n++) begin
      load({ND{gd(4'(n))}});
      chk($sformatf("R1 code %0d", n), 64'(sel_o), 64'({ND{exp_sel(4'(n))}}));
      chk("R3 valid none", 64'(none_o), 64'd0);
      chk("R3 valid multi", 64'(multi_o), 64'd0);
    end
  endtask

  task automatic t_invalid();
    for (int c = 10; c < 16; c++) begin
      load({gd(4'd0), gd(4'(c)), gd(4'd3), gd(4'(c)), gd(4'd7)});
      chk($sformatf("R2 digit1 code %0d", c), 64'(sel_o[19:10]), 64'(exp_sel(4'(c))));
      chk($sformatf("R2 digit3 code %0d", c), 64'(sel_o[39:30]), 64'(exp_sel(4'(c))));
      chk("R3 none", 64'(none_o), (c == 10) ? 64'b01010 : 64'd0);
      chk("R3 multi", 64'(multi_o), (c == 10) ? 64'd0 : 64'b01010);
    end
  endtask

  task automatic t_lower_pass();
    logic h;
    load({gd(4'd1), gd(4'd12), gd(4'd10), gd(4'd15), gd(4'd11)});
    strobe(h);
    chk("R6 lower illegal unflagged halt", 64'(h), 64'd0);
    chk("R6 lower illegal unflagged check", 64'(check_o), 64'd0);
    chk("R3 diag does not halt", 64'(halt_o), 64'd0);
  endtask

  task automatic t_parity();
    logic h;
    logic [4:0] bad;
    bad = gd(4'd5) ^ 5'b10000;
    load({gd(4'd0), gd(4'd4), bad, gd(4'd2), gd(4'd9)});
    repeat (3) @(negedge clk_i);
    chk("R10 no strobe no check", 64'(check_o), 64'd0);
    chk("R10 no strobe no halt", 64'(halt_o), 64'd0);
    strobe(h);
    chk("R7 halt within strobe cycle", 64'(h), 64'd1);
    chk("R5 parity sets check", 64'(check_o), 64'd1);
    load({ND{gd(4'd1)}});
    repeat (2) @(negedge clk_i);
    chk("R8 sticky after good load", 64'(check_o), 64'd1);
    chk("R7 halt with check", 64'(halt_o), 64'd1);
    clear();
    chk("R8 clear", 64'(check_o), 64'd0);
    chk("R8 halt cleared", 64'(halt_o), 64'd0);
  endtask

  task automatic t_range();
    logic h;
    load({gd(4'd1), gd(4'd9), gd(4'd9), gd(4'd9), gd(4'd9)});
    strobe(h);
    chk("R6 high digit at limit", 64'(check_o), 64'd0);
    load({gd(4'd2), {ND-1{gd(4'd0)}}});
    strobe(h);
    chk("R6 high digit over limit halt", 64'(h), 64'd1);
    chk("R6 high digit over limit", 64'(check_o), 64'd1);
    clear();
    load({gd(4'd11), {ND-1{gd(4'd0)}}});
    strobe(h);
    chk("R6 high digit illegal code", 64'(check_o), 64'd1);
    clear();
  endtask

  task automatic t_clear_prio();
    load({gd(4'd3), {ND-1{gd(4'd0)}}});
    @(negedge clk_i); strobe_i = 1'b1; clear_i = 1'b1;
    @(negedge clk_i); strobe_i = 1'b0; clear_i = 1'b0;
    chk("R8 clear beats strobe", 64'(check_o), 64'd0);
  endtask

  task automatic t_hold();
    load({ND{gd(4'd6)}});
    @(negedge clk_i); addr_i = {ND{gd(4'd2)}};
    @(negedge clk_i);
    chk("R4 hold without load", 64'(sel_o), 64'({ND{exp_sel(4'd6)}}));
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R9 reset empties register", 64'(sel_o), 64'({ND{10'd1}}));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_valid();
    t_invalid();
    t_lower_pass();
    t_parity();
    t_range();
    t_clear_prio();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule